// File: doc/BRIEF.md
# Dual-Modulus Swallow Counter Controller

This block is the programmable main divider of a frequency synthesizer that uses an external two-modulus prescaler, which divides by either P or P+1. It is clocked by rising edges of the prescaler output. Two counters run side by side: a main counter of width `N_W` and a swallow counter of width `A_W`. For each output cycle the modulus select stays high, asking for P+1, during the first A prescaler periods. It stays low, asking for P, for the remaining N−A periods. The total division from the VCO to the output pulse is therefore N·P + A.

The division values come from holding registers outside the block. The block samples them only at the start of each cycle, so software can rewrite them at any time without corrupting the cycle in progress. During the last prescaler period of each cycle the block raises a single-period pulse for the phase detector. On that same edge both counters reload from the held values.

Top module: `swallow_divider`

## Requirements
- R1: While reset is low, and after its release until the first prescaler edge, `mod_sel` and `div_pulse` are both low. The first rising edge after release starts a new cycle.
- R2: Within a cycle, period k counts from 0 at the first period after the reload edge. `mod_sel` is 1 (selecting P+1) for periods k < A, where A is the effective swallow value.
- R3: `mod_sel` is 0 (selecting P) for periods A ≤ k < N. With A = 0 it stays 0 for the whole cycle.
- R4: `div_pulse` is 1 only during period k = N−1. A cycle lasts exactly N prescaler periods, so the pulse recurs every N rising edges.
- R5: When the held A value exceeds the effective N, A is clamped to N, and `mod_sel` stays 1 for the whole cycle.
- R6: A held N value of 0 acts as N = 1. A pulse occurs in every period, and A is clamped to at most 1.
- R7: `n_lat` and `a_lat` are sampled only on the edge that starts a cycle. Changes made during a cycle have no effect on `mod_sel` or `div_pulse` until the next cycle.
- R8: The main count spans 1 to 2^N_W−1 and the swallow count spans 0 to 2^A_W−1, where N_W > A_W. The defaults are 10 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pre_clk | input | 1 | Prescaler output; both counters advance on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_lat | input | N_W | Held main division value N |
| a_lat | input | A_W | Held swallow value A |
| mod_sel | output | 1 | Modulus select: 1 = P+1, 0 = P |
| div_pulse | output | 1 | One prescaler period high at the end of each cycle |

## Verification
The bench builds the block with N_W = 5 and A_W = 4. This keeps every cycle at 31 periods or fewer, so random segments cover many complete cycles. The setting also makes A > N common whenever N < 15, which exercises the clamp routinely. At these widths the N = 0 case, the largest N of 31, and mid-cycle value changes are all cheap to reach directly.

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int N_W = 10,
  parameter int A_W = 7
) (
  input  logic           pre_clk,
  input  logic           rst_n,
  input  logic [N_W-1:0] n_lat,
  input  logic [A_W-1:0] a_lat,
  output logic           mod_sel,
  output logic           div_pulse
);
  localparam int PAD = N_W - A_W;

  logic [N_W-1:0] n_cnt, n_eff;
  logic [A_W-1:0] a_cnt, a_eff;
  logic           reload;

  assign n_eff  = (n_lat == '0) ? N_W'(1) : n_lat;
  assign a_eff  = ({{PAD{1'b0}}, a_lat} > n_eff) ? n_eff[A_W-1:0] : a_lat;
  assign reload = (n_cnt <= N_W'(1));

  always_ff @(posedge pre_clk or negedge rst_n) begin
    if (!rst_n) begin
      n_cnt <= '0;
      a_cnt <= '0;
    end else if (reload) begin
      n_cnt <= n_eff;
      a_cnt <= a_eff;
    end else begin
      n_cnt <= n_cnt - N_W'(1);
      if (a_cnt != '0) a_cnt <= a_cnt - A_W'(1);
    end
  end

  assign mod_sel   = (a_cnt != '0);
  assign div_pulse = (n_cnt == N_W'(1));

  p_idle_quiet_r1: assert property (@(posedge pre_clk) disable iff (!rst_n)
    (n_cnt == '0) |-> (!mod_sel && !div_pulse));

  p_count_down_r4: assert property (@(posedge pre_clk) disable iff (!rst_n)
    (n_cnt > N_W'(1)) |=> (n_cnt == $past(n_cnt) - N_W'(1)));

  p_a_hold_r3: assert property (@(posedge pre_clk) disable iff (!rst_n)
    (a_cnt == '0 && n_cnt > N_W'(1)) |=> (a_cnt == '0));

  p_a_within_n_r5: assert property (@(posedge pre_clk) disable iff (!rst_n)
    ({{PAD{1'b0}}, a_cnt} <= n_cnt));

  p_reload_sample_r7: assert property (@(posedge pre_clk) disable iff (!rst_n)
    div_pulse |=> (n_cnt == $past(n_eff) && a_cnt == $past(a_eff)));

  p_no_zero_load_r6: assert property (@(posedge pre_clk) disable iff (!rst_n)
    div_pulse |=> (n_cnt != '0));
endmodule

// File: tb/swallow_divider_bench.sv
module swallow_divider_bench;
  localparam int CLK_P = 10;
  localparam int NW = 5;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NW-1:0] n_in = '0;
  logic [AW-1:0] a_in = '0;
  logic          mod_sel, div_pulse;

  int n_checks = 0;
  int n_fails = 0;
  bit checking = 1'b0;
  bit done = 1'b0;
  string cur_tag = "";

  int started = 0;
  int k = 0;
  int cn = 1;
  int ca = 0;

  swallow_divider #(.N_W(NW), .A_W(AW)) u_swallow_divider (
    .pre_clk(clk), .rst_n(rst_n), .n_lat(n_in), .a_lat(a_in),
    .mod_sel(mod_sel), .div_pulse(div_pulse));

  always #(CLK_P/2) clk = ~clk;

  function automatic int eff_n(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int eff_a(input int a, input int n);
    return (a > n) ? n : a;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) started = 0;
    else if (started == 0 || k == cn - 1) begin
      cn = eff_n(int'(n_in));
      ca = eff_a(int'(a_in), cn);
      k = 0;
      started = 1;
    end else k = k + 1;
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d (n=%0d a=%0d k=%0d)",
               tag, what, act, exp, cn, ca, k);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && checking) begin
      check((cur_tag != "") ? cur_tag : ((started != 0 && k < ca) ? "R2" : "R3"),
            "mod_sel", int'(mod_sel), (started != 0 && k < ca) ? 1 : 0);
      check((cur_tag != "") ? cur_tag : "R4",
            "div_pulse", int'(div_pulse), (started != 0 && k == cn - 1) ? 1 : 0);
    end
  end

  task automatic run(input int cycles);
    repeat (cycles) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "mod_sel in reset", int'(mod_sel), 0);
    check("R1", "div_pulse in reset", int'(div_pulse), 0);
    run(2);
    rst_n = 1'b1;
    #1;
    check("R1", "mod_sel after release", int'(mod_sel), 0);
    check("R1", "div_pulse after release", int'(div_pulse), 0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    checking = 1'b1;
    n_in = 5'd10; a_in = 4'd3;
    do_reset();

    cur_tag = "R2"; run(40);
    cur_tag = "R3"; a_in = 4'd0; run(40);
    cur_tag = "R5"; n_in = 5'd6; a_in = 4'd12; run(30);
    cur_tag = "R6"; n_in = 5'd0; a_in = 4'd3; run(12);
    cur_tag = "R8"; n_in = 5'd31; a_in = 4'd15; run(100);

    cur_tag = "R7";
    n_in = 5'd20; a_in = 4'd5;
    run(25);
    while (!div_pulse) @(negedge clk);
    run(3);
    n_in = 5'd3; a_in = 4'd2;
    run(2);
    n_in = 5'd9; a_in = 4'd7;
    run(50);

    cur_tag = "";
    for (int seg = 0; seg < 300; seg++) begin
      n_in = NW'($urandom_range(0, 31));
      a_in = AW'($urandom_range(0, 15));
      if ($urandom_range(0, 19) == 0) do_reset();
      run($urandom_range(1, 80));
    end

    run(5);
    checking = 1'b0;
    finish_run();
  end
endmodule